// File: doc/BRIEF.md
# USB Controller Core Configuration Register

This block is the global configuration word of a dual-role USB controller. Software writes it once through a plain 32-bit write port and can read it back at any time. Each field has its own access rule: most option bits are read/write, and the debug corruption control can be written but always reads back as zero. The PHY-selection bits are fixed constants. The session-request capability bit holds a value only when the controller is built with that capability. Reserved positions read as zero. The stored fields go out on dedicated output ports to the rest of the core.

Bits 29 and 30 request a forced operating mode, host or device. A mode sequencer owns the reported operating mode. When a write changes the requested mode, the sequencer clears `mode_valid_o` and counts a settle interval in clock cycles. Only when the count ends does it move `op_mode_o` to the new mode and raise `mode_valid_o` again. The interval comes from either a full-length parameter or a shortened parameter for scaled-down runs, chosen by `SCALE_DOWN`.

The sequencer has two states. In STEADY the reported mode is valid. The transition STEADY->SETTLE happens on a write whose decoded request differs from the current target. In SETTLE the count runs. The transition SETTLE->SETTLE (restart) happens on a write with a new, different request, and reloads the count. The transition SETTLE->STEADY happens when the count reaches zero and commits the target mode.

Top module: `usbcfg_top`

## Requirements
- R1: After reset the read word is 0x0000_1410, `op_mode_o` is normal (2'b00) and `mode_valid_o` is 1.
- R2: Bit 31 is write-only. A write stores it and drives it on `dbg_corrupt_o`, and bit 31 of the read word is always 0.
- R3: Bit 28, bits 25:18, bit 9, bit 7 and bits 2:0 are read/write with reset value 0. They read back as written and appear on `tx_end_dly_o`, `phy_opt_o`, `hnp_en_o`, `sdr_sel_o` and `tout_cal_o`.
- R4: Bits 13:10 hold the turnaround time. They are read/write with reset value 5, drive `turnaround_o`, and keep their value when no write occurs.
- R5: Bit 8 (session request capable) stores a write only when `SRP_MODE_EN` is 1. Otherwise it ignores writes, reads 0 and keeps `srp_en_o` at 0.
- R6: Read bits 6:3 are the constant 4'b0010 (bit 4 set) whatever is written.
- R7: Reserved bits 27:26 and 17:14 read as 0 whatever is written.
- R8: Bits 30 (force device) and 29 (force host) are read/write. A write whose decoded request differs from the current target drops `mode_valid_o` for exactly SETTLE cycles, counted from the write edge, with `op_mode_o` unchanged. On the next edge `op_mode_o` takes the new mode (host 2'b01, device 2'b10) and `mode_valid_o` returns to 1.
- R9: When bits 29 and 30 are both 1, the request decodes to host.
- R10: Clearing both force bits returns `op_mode_o` to normal after the same settle interval.
- R11: A write that repeats the current target request neither starts nor restarts the count. A write with a different request during the count restarts it from that write with the new target.
- R12: SETTLE equals `SETTLE_SCALED` when `SCALE_DOWN` is 1 and `SETTLE_FULL` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read view of the configuration word |
| dbg_corrupt_o | output | 1 | Debug corruption control (bit 31) |
| tx_end_dly_o | output | 1 | Transmit end delay option (bit 28) |
| phy_opt_o | output | 8 | PHY option bits 25:18 |
| turnaround_o | output | 4 | Turnaround time in PHY clocks |
| hnp_en_o | output | 1 | Host negotiation capability enable |
| srp_en_o | output | 1 | Session request capability enable |
| sdr_sel_o | output | 1 | Data-rate select option (bit 7) |
| tout_cal_o | output | 3 | Interpacket timeout calibration |
| op_mode_o | output | 2 | Reported operating mode: 00 normal, 01 host, 10 device |
| mode_valid_o | output | 1 | Low while a mode change settles |

## Verification
The bench counts the low window of `mode_valid_o` edge by edge on two builds with different settle lengths. An off-by-one counter would show up as one cycle too many or too few, and a sequencer that updated the mode early would show the new mode while the valid flag is still low. It sets both force bits together and expects host, so a design that favoured device would fail. A repeated write of the pending request must not stretch the window. A differing request in mid-count must restart it with the new target, which catches a design that ignores or merges the two requests. It writes all ones and checks the read word: a leak from the write-only bit, the reserved bits or the constant PHY-select bits would show in the word. A build without session-request capability that still latched bit 8 would also be caught.

// File: rtl/usbcfg_pkg.sv
package usbcfg_pkg;

    localparam int REG_W    = 32;
    localparam int OPT_W    = 8;
    localparam int TRN_W    = 4;
    localparam int CAL_W    = 3;

    localparam int B_DBG    = 31;
    localparam int B_FDEV   = 30;
    localparam int B_FHOST  = 29;
    localparam int B_TXEND  = 28;
    localparam int OPT_LO   = 18;
    localparam int TRN_LO   = 10;
    localparam int B_HNP    = 9;
    localparam int B_SRP    = 8;
    localparam int B_SDR    = 7;
    localparam int RO_LO    = 3;
    localparam int RO_W     = 4;
    localparam logic [RO_W-1:0] RO_VAL = 4'b0010;
    localparam int CAL_LO   = 0;

    typedef enum logic [1:0] {
        OPM_NORMAL = 2'b00,
        OPM_HOST   = 2'b01,
        OPM_DEVICE = 2'b10
    } op_mode_e;

    typedef enum logic {
        SEQ_STEADY = 1'b0,
        SEQ_SETTLE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             dbg;
        logic             fdev;
        logic             fhost;
        logic             txend;
        logic [OPT_W-1:0] opt;
        logic [TRN_W-1:0] trn;
        logic             hnp;
        logic             srp;
        logic             sdr;
        logic [CAL_W-1:0] cal;
    } cfg_fields_t;

    function automatic op_mode_e decode_req(input logic fhost, input logic fdev);
        if (fhost)     return OPM_HOST;
        else if (fdev) return OPM_DEVICE;
        else           return OPM_NORMAL;
    endfunction

endpackage

// File: rtl/usbcfg_fields.sv
module usbcfg_fields
    import usbcfg_pkg::*;
#(
    parameter bit          SRP_WRITABLE = 1'b1,
    parameter logic [TRN_W-1:0] TRN_RESET = 4'd5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_fields_t      cfg_o,
    output logic [REG_W-1:0] rd_data
);

    cfg_fields_t cfg_q;

    localparam cfg_fields_t CFG_RESET = '{
        dbg: 1'b0, fdev: 1'b0, fhost: 1'b0, txend: 1'b0,
        opt: '0, trn: TRN_RESET, hnp: 1'b0, srp: 1'b0,
        sdr: 1'b0, cal: '0
    };

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q.dbg   <= wr_data[B_DBG];
            cfg_q.fdev  <= wr_data[B_FDEV];
            cfg_q.fhost <= wr_data[B_FHOST];
            cfg_q.txend <= wr_data[B_TXEND];
            cfg_q.opt   <= wr_data[OPT_LO +: OPT_W];
            cfg_q.trn   <= wr_data[TRN_LO +: TRN_W];
            cfg_q.hnp   <= wr_data[B_HNP];
            cfg_q.sdr   <= wr_data[B_SDR];
            cfg_q.cal   <= wr_data[CAL_LO +: CAL_W];
            cfg_q.srp   <= SRP_WRITABLE ? wr_data[B_SRP] : 1'b0;
        end
    end

    // Read view: write-only and reserved positions stay zero.
    always_comb begin
        rd_data                    = '0;
        rd_data[B_FDEV]            = cfg_q.fdev;
        rd_data[B_FHOST]           = cfg_q.fhost;
        rd_data[B_TXEND]           = cfg_q.txend;
        rd_data[OPT_LO +: OPT_W]   = cfg_q.opt;
        rd_data[TRN_LO +: TRN_W]   = cfg_q.trn;
        rd_data[B_HNP]             = cfg_q.hnp;
        rd_data[B_SRP]             = cfg_q.srp;
        rd_data[B_SDR]             = cfg_q.sdr;
        rd_data[RO_LO +: RO_W]     = RO_VAL;
        rd_data[CAL_LO +: CAL_W]   = cfg_q.cal;
    end

    assign cfg_o = cfg_q;

    AST_CAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q.cal == $past(wr_data[CAL_LO +: CAL_W])); // R3

    AST_TRN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q.trn)); // R4

    AST_DBG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q.dbg == $past(wr_data[B_DBG])); // R2

    generate
        if (!SRP_WRITABLE) begin : g_srp_locked
            AST_SRP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> !cfg_q.srp); // R5
        end
    endgenerate

endmodule

// File: rtl/usbcfg_mode_seq.sv
module usbcfg_mode_seq
    import usbcfg_pkg::*;
#(
    parameter int SETTLE_CYC = 30000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_fhost,
    input  logic     wr_fdev,
    output op_mode_e op_mode_o,
    output logic     mode_valid_o
);

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    op_mode_e       tgt_q, tgt_d;
    op_mode_e       cur_q, cur_d;
    op_mode_e       req;
    logic           start;

    assign req   = decode_req(wr_fhost, wr_fdev);
    assign start = wr_en && (req != tgt_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tgt_d   = tgt_q;
        cur_d   = cur_q;
        unique case (state_q)
            SEQ_STEADY: begin
                if (start) begin
                    state_d = SEQ_SETTLE;
                    cnt_d   = CNT_LAST;
                    tgt_d   = req;
                end
            end
            SEQ_SETTLE: begin
                if (start) begin
                    cnt_d = CNT_LAST;
                    tgt_d = req;
                end else if (cnt_q == '0) begin
                    state_d = SEQ_STEADY;
                    cur_d   = tgt_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = SEQ_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_STEADY;
            cnt_q   <= '0;
            tgt_q   <= OPM_NORMAL;
            cur_q   <= OPM_NORMAL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        op_mode_o    = cur_q;
        mode_valid_o = (state_q == SEQ_STEADY);
    end

    AST_MODE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> $past(state_q == SEQ_SETTLE && cnt_q == '0)); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R8

    AST_HOST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fhost) |=> tgt_q == OPM_HOST); // R9

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid_o |-> tgt_q == cur_q); // R11

endmodule

// File: rtl/usbcfg_top.sv
module usbcfg_top
    import usbcfg_pkg::*;
#(
    parameter bit SRP_MODE_EN   = 1'b1,
    parameter bit SCALE_DOWN    = 1'b0,
    parameter int SETTLE_FULL   = 1500000,
    parameter int SETTLE_SCALED = 30000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        dbg_corrupt_o,
    output logic        tx_end_dly_o,
    output logic [7:0]  phy_opt_o,
    output logic [3:0]  turnaround_o,
    output logic        hnp_en_o,
    output logic        srp_en_o,
    output logic        sdr_sel_o,
    output logic [2:0]  tout_cal_o,
    output logic [1:0]  op_mode_o,
    output logic        mode_valid_o
);

    localparam int SETTLE_CYC = SCALE_DOWN ? SETTLE_SCALED : SETTLE_FULL;

    cfg_fields_t cfg;
    op_mode_e    mode;

    usbcfg_fields #(
        .SRP_WRITABLE (SRP_MODE_EN),
        .TRN_RESET    (4'd5)
    ) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_o   (cfg),
        .rd_data (rd_data)
    );

    usbcfg_mode_seq #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_fhost     (wr_data[B_FHOST]),
        .wr_fdev      (wr_data[B_FDEV]),
        .op_mode_o    (mode),
        .mode_valid_o (mode_valid_o)
    );

    assign dbg_corrupt_o = cfg.dbg;
    assign tx_end_dly_o  = cfg.txend;
    assign phy_opt_o     = cfg.opt;
    assign turnaround_o  = cfg.trn;
    assign hnp_en_o      = cfg.hnp;
    assign srp_en_o      = cfg.srp;
    assign sdr_sel_o     = cfg.sdr;
    assign tout_cal_o    = cfg.cal;
    assign op_mode_o     = mode;

endmodule

// File: tb/usbcfg_top_tb_top.sv
`timescale 1ns/1ps
module usbcfg_top_tb_top;

    localparam int SA = 12;   // scaled build
    localparam int SB = 40;   // full build
    localparam logic [31:0] MASK = 32'h73FC_3F87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;

    logic [31:0] rd_a, rd_b;
    logic        dbg_a, dbg_b, txe_a, txe_b, hnp_a, hnp_b, srp_a, srp_b, sdr_a, sdr_b;
    logic [7:0]  opt_a, opt_b;
    logic [3:0]  trn_a, trn_b;
    logic [2:0]  cal_a, cal_b;
    logic [1:0]  mode_a, mode_b;
    logic        val_a, val_b;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    usbcfg_top #(.SRP_MODE_EN(1'b1), .SCALE_DOWN(1'b1), .SETTLE_FULL(SB), .SETTLE_SCALED(SA)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
        .dbg_corrupt_o(dbg_a), .tx_end_dly_o(txe_a), .phy_opt_o(opt_a), .turnaround_o(trn_a),
        .hnp_en_o(hnp_a), .srp_en_o(srp_a), .sdr_sel_o(sdr_a), .tout_cal_o(cal_a),
        .op_mode_o(mode_a), .mode_valid_o(val_a));

    usbcfg_top #(.SRP_MODE_EN(1'b0), .SCALE_DOWN(1'b0), .SETTLE_FULL(SB), .SETTLE_SCALED(SA)) dut_nosrp_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
        .dbg_corrupt_o(dbg_b), .tx_end_dly_o(txe_b), .phy_opt_o(opt_b), .turnaround_o(trn_b),
        .hnp_en_o(hnp_b), .srp_en_o(srp_b), .sdr_sel_o(sdr_b), .tout_cal_o(cal_b),
        .op_mode_o(mode_b), .mode_valid_o(val_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] d, input bit srp);
        logic [31:0] r;
        r = (d & MASK) | 32'h0000_0010;
        if (!srp) r[8] = 1'b0;
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // n0 = edges already elapsed since the write that started the count.
    task automatic settle_watch(input string req, input logic [1:0] oldm,
                                input logic [1:0] newm, input int n0);
        for (int n = n0; n <= SB + 1; n++) begin
            if (n == SA) begin
                chk({req, " R12 A last low"}, {29'd0, val_a, mode_a}, {29'd0, 1'b0, oldm});
            end
            if (n == SA + 1) begin
                chk({req, " R12 A commit"}, {29'd0, val_a, mode_a}, {29'd0, 1'b1, newm});
            end
            if (n == SB) begin
                chk({req, " R12 B last low"}, {29'd0, val_b, mode_b}, {29'd0, 1'b0, oldm});
            end
            if (n == SB + 1) begin
                chk({req, " R12 B commit"}, {29'd0, val_b, mode_b}, {29'd0, 1'b1, newm});
            end
            if (n < SB + 1) step();
        end
    endtask

    task automatic t_reset();
        chk("R1 read A", rd_a, 32'h0000_1410);
        chk("R1 read B", rd_b, 32'h0000_1410);
        chk("R1 mode", {30'd0, mode_a}, 32'd0);
        chk("R1 valid", {31'd0, val_a}, 32'd1);
        chk("R4 turnaround reset", {28'd0, trn_a}, 32'd5);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        d = 32'h9FFC_FFFF & ~32'h6000_0000;   // all ones except force bits
        write(d);
        chk("R2 read zero", {31'd0, rd_a[31]}, 32'd0);
        chk("R2 dbg out", {31'd0, dbg_a}, 32'd1);
        chk("R3/R4/R6/R7 read A", rd_a, exp_rd(d, 1'b1));
        chk("R5 read B no srp", rd_b, exp_rd(d, 1'b0));
        chk("R5 srp out A", {31'd0, srp_a}, 32'd1);
        chk("R5 srp out B", {31'd0, srp_b}, 32'd0);
        chk("R3 outputs", {txe_a, opt_a, hnp_a, sdr_a, cal_a}, {1'b1, 8'hFF, 1'b1, 1'b1, 3'h7});
        chk("R4 turnaround", {28'd0, trn_a}, 32'hF);
        chk("R6 constants", {28'd0, rd_a[6:3]}, 32'h2);
        chk("R7 reserved", {rd_a[27:26], rd_a[17:14]}, 32'd0);
        step();
        chk("R4 hold", {28'd0, trn_a}, 32'hF);
        chk("R1 no settle", {31'd0, val_a}, 32'd1);
        d = 32'h0004_2A05;
        write(d);
        chk("R3 pattern2 A", rd_a, exp_rd(d, 1'b1));
        chk("R3 pattern2 B", rd_b, exp_rd(d, 1'b0));
        chk("R2 dbg cleared", {31'd0, dbg_a}, 32'd0);
    endtask

    task automatic t_force_host();
        write(32'h2000_0000);
        chk("R8 readback", rd_a, exp_rd(32'h2000_0000, 1'b1));
        chk("R8 valid drops", {31'd0, val_a}, 32'd0);
        settle_watch("R8 host", 2'b00, 2'b01, 1);
        step();
        chk("R8 steady", {29'd0, val_a, mode_a}, {29'd0, 1'b1, 2'b01});
    endtask

    task automatic t_clear();
        write(32'h0000_0000);
        settle_watch("R10 clear", 2'b01, 2'b00, 1);
    endtask

    task automatic t_both();
        write(32'h6000_0000);
        chk("R9 readback", rd_a, exp_rd(32'h6000_0000, 1'b1));
        settle_watch("R9 both", 2'b00, 2'b01, 1);
        write(32'h0000_0000);
        settle_watch("R9 back normal", 2'b01, 2'b00, 1);
    endtask

    task automatic t_restart();
        write(32'h2000_0000);
        for (int i = 0; i < 5; i++) step();
        write(32'h4000_0000);
        settle_watch("R11 restart", 2'b00, 2'b10, 1);
    endtask

    task automatic t_same_request();
        write(32'h2000_0000);                    // device -> host, n=1
        for (int i = 0; i < 4; i++) step();      // n=5
        write(32'h2004_0000);                    // same request, n=6
        settle_watch("R11 no restart", 2'b10, 2'b01, 6);
        write(32'h2000_0003);                    // same request in steady state
        chk("R11 steady rewrite", {29'd0, val_a, mode_a}, {29'd0, 1'b1, 2'b01});
        chk("R11 rewrite stored", {29'd0, cal_a}, 32'd3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  %0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_fields();
        t_force_host();
        t_clear();
        t_both();
        t_restart();
        t_same_request();
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule